// File: doc/BRIEF.md
# Multi-port GPIO controller with per-port interrupts

This block drives a bank of general-purpose pins arranged as a parameterised number of 8-pin ports (one to seven). Software programs each pin over a simple 32-bit register bus: its output value, one of four drive modes, its pull-up, and its interrupt behaviour. The pad side of each pin is a plain output value, an output enable and a pull-up enable, all derived from the registers. The pad input is brought through a two-stage synchroniser before it is read back or examined for edges.

Every pin can flag an interrupt on either its rising or its falling edge, selected per pin. The detected edge is held in a sticky event bit that software clears by writing a 1. A per-pin enable masks events into a single interrupt line per port, and a per-pin force bit injects events for test. A global control word at address zero enables event capture, carries a spare synchroniser-select bit, and reports a build version and the port count.

Top module: `gpio_bank`

## Requirements
- R1: Port p owns the byte addresses p*0x30 .. p*0x30+0x2F. Within a window: input data +0x04, output data +0x08, drive mode +0x0C, pull-up disable +0x10, event +0x14, interrupt enable +0x18, force +0x1C, edge select +0x20. Writable registers read back what was written; bits above a register's width (above bit 15 for drive mode, above bit 7 for the others) read zero and ignore writes; addresses that decode to nothing read zero.
- R2: The control word at address 0x00 has bit 0 = capture enable and bit 1 = a stored spare select bit, both writable; bits 8..2 read the VERSION_ID parameter, bits 15..9 read NUM_PORTS, bits 31..16 read zero.
- R3: The input data register shows pad_in_i after two rising clock edges: a pad change driven before edge n is visible on a read after edge n+1, not after edge n.
- R4: Drive mode uses two bits per pin, pin k at bits 2k+1..2k: 00 input (pad_oe_o low), 01 push-pull (always enabled), 10 open-drain (enabled only when the output bit is 0), 11 open-source (enabled only when the output bit is 1). pad_out_o always equals the output data bit.
- R5: A pull-up disable bit of 1 drives pad_pu_en_o low for that pin; 0 drives it high.
- R6: Edge select bit 1 makes a synchronised rising edge set the event bit, bit 0 a falling edge; the opposite edge leaves the event bit unchanged.
- R7: An event bit stays set until a write to the event register with a 1 in that position; writing 0 there leaves it set.
- R8: irq_o[p] is high exactly when some pin of port p has both its event bit and its enable bit set.
- R9: A force bit of 1 sets that pin's event bit on the following edge while capture is enabled; the force register reads back its value.
- R10: When an edge of the selected polarity and a clearing write to the same event bit fall on the same clock edge, the event bit ends up set.
- R11: With capture disabled, neither pad edges nor force bits set event bits, and edges that occurred while disabled are not reported after capture is re-enabled.
- R12: After reset all writable registers are zero: no output enabled, all pull-ups enabled, no event, every irq_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pad_in_i | input | NUM_PORTS*8 | Pad input levels, asynchronous |
| pad_out_o | output | NUM_PORTS*8 | Pad output values |
| pad_oe_o | output | NUM_PORTS*8 | Pad output enables |
| pad_pu_en_o | output | NUM_PORTS*8 | Pad pull-up enables |
| irq_o | output | NUM_PORTS | Interrupt line per port |

## Verification
The bench builds the block with three ports and a version ID of 0x15, so port 0 shares its window with the control word, port 2 sits at a non-zero base, and the core-count field reads a value other than one. Three ports also leave address 0x90, the start of an absent fourth window, available to show that undecoded addresses read zero. Edge and collision cases are driven on exact clock edges counted through the synchroniser, so the set-wins rule and the two-edge input latency are pinned to single cycles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int MAX_PORTS     = 7;
  localparam int PORT_STRIDE   = 'h30;
  localparam int OFF_W         = 6;

  localparam logic [OFF_W-1:0] OFF_DIN  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_DOUT = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MODE = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_PULL = 6'h10;
  localparam logic [OFF_W-1:0] OFF_EVT  = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IEN  = 6'h18;
  localparam logic [OFF_W-1:0] OFF_FRC  = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_EDGE = 6'h20;

  typedef enum logic [1:0] {
    DRV_INPUT = 2'b00,
    DRV_PUSH  = 2'b01,
    DRV_SINK  = 2'b10,
    DRV_SRC   = 2'b11
  } drive_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_bank_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       dout_i,
  input  logic       pu_dis_i,
  output logic       pad_out_o,
  output logic       pad_oe_o,
  output logic       pad_pu_en_o
);
  drive_mode_e mode;
  assign mode = drive_mode_e'(mode_i);

  always_comb begin
    case (mode)
      DRV_PUSH: pad_oe_o = 1'b1;
      DRV_SINK: pad_oe_o = ~dout_i;
      DRV_SRC:  pad_oe_o = dout_i;
      default:  pad_oe_o = 1'b0;
    endcase
  end

  assign pad_out_o   = dout_i;
  assign pad_pu_en_o = ~pu_dis_i;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_en_i,
  input  logic                     wr_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic [15:0]              wdata_i,
  output logic [31:0]              rdata_o,
  input  logic [PINS_PER_PORT-1:0] pin_sync_i,
  output logic [PINS_PER_PORT-1:0] dout_o,
  output logic [2*PINS_PER_PORT-1:0] mode_o,
  output logic [PINS_PER_PORT-1:0] pu_dis_o,
  output logic [PINS_PER_PORT-1:0] evt_o,
  output logic                     irq_o
);
  localparam int N = PINS_PER_PORT;

  logic [N-1:0]   dout_q, pull_q, evt_q, ien_q, frc_q, edge_q, prev_q;
  logic [2*N-1:0] mode_q;
  logic [N-1:0]   hit, set_mask, clr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      mode_q <= '0;
      pull_q <= '0;
      ien_q  <= '0;
      frc_q  <= '0;
      edge_q <= '0;
    end else if (wr_i) begin
      case (off_i)
        OFF_DOUT: dout_q <= wdata_i[N-1:0];
        OFF_MODE: mode_q <= wdata_i[2*N-1:0];
        OFF_PULL: pull_q <= wdata_i[N-1:0];
        OFF_IEN:  ien_q  <= wdata_i[N-1:0];
        OFF_FRC:  frc_q  <= wdata_i[N-1:0];
        OFF_EDGE: edge_q <= wdata_i[N-1:0];
        default: ;
      endcase
    end
  end

  // prev tracks the pin even when capture is off, so stale edges are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_sync_i;
  end

  assign hit      = (pin_sync_i & ~prev_q & edge_q) | (~pin_sync_i & prev_q & ~edge_q);
  assign set_mask = cap_en_i ? (hit | frc_q) : '0;
  assign clr_mask = (wr_i && off_i == OFF_EVT) ? wdata_i[N-1:0] : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_mask) | set_mask;
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_DIN:  rdata_o[N-1:0]   = pin_sync_i;
      OFF_DOUT: rdata_o[N-1:0]   = dout_q;
      OFF_MODE: rdata_o[2*N-1:0] = mode_q;
      OFF_PULL: rdata_o[N-1:0]   = pull_q;
      OFF_EVT:  rdata_o[N-1:0]   = evt_q;
      OFF_IEN:  rdata_o[N-1:0]   = ien_q;
      OFF_FRC:  rdata_o[N-1:0]   = frc_q;
      OFF_EDGE: rdata_o[N-1:0]   = edge_q;
      default: ;
    endcase
  end

  assign dout_o   = dout_q;
  assign mode_o   = mode_q;
  assign pu_dis_o = pull_q;
  assign evt_o    = evt_q;
  assign irq_o    = |(evt_q & ien_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int          NUM_PORTS  = 7,
  parameter int          ADDR_W     = 9,
  parameter logic [6:0]  VERSION_ID = 7'h01
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic                          bus_wr_i,
  input  logic [31:0]                   bus_wdata_i,
  output logic [31:0]                   bus_rdata_o,
  input  logic [NUM_PORTS*8-1:0]        pad_in_i,
  output logic [NUM_PORTS*8-1:0]        pad_out_o,
  output logic [NUM_PORTS*8-1:0]        pad_oe_o,
  output logic [NUM_PORTS*8-1:0]        pad_pu_en_o,
  output logic [NUM_PORTS-1:0]          irq_o
);
  localparam int NPINS = NUM_PORTS * PINS_PER_PORT;

  logic [1:0]           ctrl_q;
  logic                 ctrl_sel;
  logic [31:0]          ctrl_rd;
  logic [NPINS-1:0]     pin_sync;
  logic [NPINS-1:0]     dout_all, pu_dis_all, evt_all;
  logic [2*NPINS-1:0]   mode_all;
  logic [NUM_PORTS-1:0] port_sel;
  logic [31:0]          port_rd [NUM_PORTS];
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata_i[31:16];

  assign ctrl_sel = (bus_addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ctrl_q <= '0;
    else if (bus_wr_i && ctrl_sel)  ctrl_q <= bus_wdata_i[1:0];
  end

  assign ctrl_rd = {16'h0, 7'(NUM_PORTS), VERSION_ID, ctrl_q};

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int BASE = p * PORT_STRIDE;
    localparam int LO   = p * PINS_PER_PORT;
    logic [OFF_W-1:0] off;

    assign port_sel[p] = (int'(bus_addr_i) >= BASE) && (int'(bus_addr_i) < BASE + PORT_STRIDE);
    assign off         = OFF_W'(bus_addr_i - ADDR_W'(BASE));

    gpio_port_regs u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_en_i   (ctrl_q[0]),
      .wr_i       (bus_wr_i && port_sel[p]),
      .off_i      (off),
      .wdata_i    (bus_wdata_i[15:0]),
      .rdata_o    (port_rd[p]),
      .pin_sync_i (pin_sync[LO +: PINS_PER_PORT]),
      .dout_o     (dout_all[LO +: PINS_PER_PORT]),
      .mode_o     (mode_all[2*LO +: 2*PINS_PER_PORT]),
      .pu_dis_o   (pu_dis_all[LO +: PINS_PER_PORT]),
      .evt_o      (evt_all[LO +: PINS_PER_PORT]),
      .irq_o      (irq_o[p])
    );
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    gpio_pad_drive u_drv (
      .mode_i      (mode_all[2*i +: 2]),
      .dout_i      (dout_all[i]),
      .pu_dis_i    (pu_dis_all[i]),
      .pad_out_o   (pad_out_o[i]),
      .pad_oe_o    (pad_oe_o[i]),
      .pad_pu_en_o (pad_pu_en_o[i])
    );
  end

  always_comb begin
    bus_rdata_o = ctrl_sel ? ctrl_rd : 32'h0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_sel[p]) bus_rdata_o = bus_rdata_o | port_rd[p];
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PORTS = 7,
  parameter int ADDR_W    = 9
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        bus_addr_i,
  input logic                     bus_wr_i,
  input logic [31:0]              bus_wdata_i,
  input logic [31:0]              bus_rdata_o,
  input logic [NUM_PORTS*8-1:0]   pad_out_o,
  input logic [NUM_PORTS*8-1:0]   pad_oe_o,
  input logic [NUM_PORTS*16-1:0]  mode_all_i,
  input logic [NUM_PORTS*8-1:0]   evt_all_i,
  input logic                     cap_en_i
);
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[31:16] == 16'h0); // R1

  AST_CTRL_CORE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == '0) |-> (bus_rdata_o[15:9] == 7'(NUM_PORTS))); // R2

  for (genvar i = 0; i < NUM_PORTS*8; i++) begin : g_pin
    localparam int PORT = i / 8;
    localparam int BIT  = i % 8;
    logic clr_this;
    assign clr_this = bus_wr_i && (int'(bus_addr_i) == PORT*'h30 + 'h14) && bus_wdata_i[BIT];

    AST_OE_OFF_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_all_i[2*i +: 2] == 2'b00) |-> !pad_oe_o[i]); // R4

    AST_OE_OPEN_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_all_i[2*i +: 2] == 2'b10) |-> (pad_oe_o[i] == !pad_out_o[i])); // R4

    AST_OE_OPEN_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_all_i[2*i +: 2] == 2'b11) |-> (pad_oe_o[i] == pad_out_o[i])); // R4

    AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_all_i[i] && !clr_this) |=> evt_all_i[i]); // R7

    AST_EVT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cap_en_i && !evt_all_i[i]) |=> !evt_all_i[i]); // R11
  end
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o),
  .mode_all_i  (mode_all),
  .evt_all_i   (evt_all),
  .cap_en_i    (ctrl_q[0])
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  localparam int         NP  = 3;
  localparam int         AW  = 9;
  localparam logic [6:0] VER = 7'h15;
  localparam int         NPIN = NP * 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe, pad_pu_en;
  logic [NP-1:0]   irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .ADDR_W(AW), .VERSION_ID(VER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_en_o(pad_pu_en), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    bus_addr = AW'(addr);
    #1 data = bus_rdata;
  endtask

  function automatic int ra(input int port, input int off);
    return port * 'h30 + off;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d);          chk("R12 ctrl after reset", d, 32'h654);
    rd(ra(1,'h0C), d); chk("R12 mode zero", d, 0);
    rd(ra(2,'h14), d); chk("R12 event zero", d, 0);
    chk("R12 oe off", 32'(pad_oe), 0);
    chk("R12 pull-ups on", 32'(pad_pu_en), 32'hFF_FFFF);
    chk("R12 irq low", 32'(irq), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 ctrl writable bits, fixed fields", d, 32'h657);
    wr(0, 32'h1);
    rd(0, d); chk("R2 ctrl enable only", d, 32'h655);
    wr(ra(1,'h0C), 32'hFFFF_FFFF);
    rd(ra(1,'h0C), d); chk("R1 mode width 16", d, 32'hFFFF);
    wr(ra(1,'h0C), 32'h0);
    wr(ra(2,'h08), 32'h1A5);
    rd(ra(2,'h08), d); chk("R1 dout width 8", d, 32'hA5);
    chk("R4 pad_out follows dout", 32'(pad_out[23:16]), 32'hA5);
    wr(ra(1,'h04), 32'hFF);
    rd(ra(1,'h04), d); chk("R1 input reg not writable", d, 0);
    rd('h90, d); chk("R1 absent window reads zero", d, 0);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk);
    pad_in[15:8] = 8'h3C;
    rd(ra(1,'h04), d); chk("R3 no change before edge", d, 0);
    tick(1);
    rd(ra(1,'h04), d); chk("R3 not visible after one edge", d, 0);
    tick(1);
    rd(ra(1,'h04), d); chk("R3 visible after two edges", d, 32'h3C);
  endtask

  task automatic t_drive;
    wr(ra(0,'h0C), 32'hE4);
    wr(ra(0,'h08), 32'h00);
    chk("R4 oe with out=0", 32'(pad_oe[3:0]), 32'h6);
    wr(ra(0,'h08), 32'h0F);
    chk("R4 oe with out=1", 32'(pad_oe[3:0]), 32'hA);
    chk("R4 pad_out", 32'(pad_out[3:0]), 32'hF);
    wr(ra(0,'h08), 32'h00);
    wr(ra(0,'h0C), 32'h00);
  endtask

  task automatic t_pull;
    wr(ra(2,'h10), 32'h0F);
    chk("R5 pull-up disable polarity", 32'(pad_pu_en[23:16]), 32'hF0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(ra(0,'h20), 32'h01);
    wr(ra(0,'h14), 32'hFF);
    @(negedge clk); pad_in[1:0] = 2'b11;
    tick(4);
    rd(ra(0,'h14), d); chk("R6 rising sets pin0 only", d, 32'h01);
    pad_in[1:0] = 2'b00;
    tick(4);
    rd(ra(0,'h14), d); chk("R6 falling sets pin1 only", d, 32'h03);
  endtask

  task automatic t_sticky_irq;
    logic [31:0] d;
    wr(ra(0,'h14), 32'h00);
    rd(ra(0,'h14), d); chk("R7 zero write keeps events", d, 32'h03);
    chk("R8 irq low while disabled", 32'(irq[0]), 0);
    wr(ra(0,'h18), 32'h02);
    chk("R8 irq on enabled event", 32'(irq[0]), 1);
    wr(ra(0,'h14), 32'h02);
    rd(ra(0,'h14), d); chk("R7 one write clears bit", d, 32'h01);
    chk("R8 irq drops after clear", 32'(irq[0]), 0);
  endtask

  task automatic t_force;
    logic [31:0] d;
    wr(ra(2,'h18), 32'h80);
    wr(ra(2,'h1C), 32'h80);
    tick(1);
    rd(ra(2,'h14), d); chk("R9 force sets event", d, 32'h80);
    rd(ra(2,'h1C), d); chk("R9 force readback", d, 32'h80);
    chk("R8 port2 irq", 32'(irq), 32'h4);
    wr(ra(2,'h1C), 32'h00);
    wr(ra(2,'h14), 32'h80);
    rd(ra(2,'h14), d); chk("R9 event clear after force off", d, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk); pad_in[0] = 1'b1;
    tick(2);
    bus_addr = AW'(ra(0,'h14)); bus_wdata = 32'h01; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(ra(0,'h14), d); chk("R10 set wins over clear", d, 32'h01);
    wr(ra(0,'h14), 32'h01);
    rd(ra(0,'h14), d); chk("R7 clear without edge", d, 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(0, 32'h0);
    @(negedge clk); pad_in[0] = 1'b0;
    tick(4);
    pad_in[0] = 1'b1;
    tick(4);
    wr(ra(2,'h1C), 32'h01);
    tick(2);
    rd(ra(0,'h14), d); chk("R11 edge ignored when disabled", d, 0);
    rd(ra(2,'h14), d); chk("R11 force ignored when disabled", d, 0);
    wr(ra(2,'h1C), 32'h00);
    wr(0, 32'h1);
    tick(4);
    rd(ra(0,'h14), d); chk("R11 no replay after enable", d, 0);
    chk("R11 irq low", 32'(irq), 0);
  endtask

  initial begin
    #500us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_regs();
    t_input();
    t_drive();
    t_pull();
    t_edge();
    t_sticky_irq();
    t_force();
    t_collide();
    t_disable();
    tick(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule